// File: doc/BRIEF.md
# Delay-Line Tap Lock Controller

This block is the digital half of a delay-locked timing generator. A phase detector outside the block compares a reference clock with a copy that has passed through a multi-tap delay line. When the copy is early it raises a pump-up pulse, and when the copy is late it raises a pump-down pulse. The controller turns those pulses into a tap choice. It holds the chosen tap as a single set bit in a bidirectional shift register. Pump-up moves the bit toward the longer-delay end, and pump-down moves it toward the shorter-delay end. A priority encoder turns the bit position into the binary select that drives the delay-line multiplexer.

When the detector stays quiet for a run of consecutive cycles, the loop is taken to have closed and a lock flag is raised. Any later error pulse clears the flag and adjustment resumes. The one-hot pointer is also brought out so that the loop state can be observed.

All outputs come from registers, so each one reflects the pulses sampled at the previous rising edge.

Top module: `tap_lock_ctrl`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `tap_ptr_o` equals 1 (bit 0 set), `tap_sel_o` equals 0 and `locked_o` is 0.
- R2: A rising edge with `pump_up_i`=1 and `pump_dn_i`=0 moves the set bit from index k to index k+1 when k is below the top tap.
- R3: A rising edge with `pump_dn_i`=1 and `pump_up_i`=0 moves the set bit from index k to index k-1 when k is above 0.
- R4: A pump-up with the bit at the top index (15 by default) leaves the pointer unchanged. The pointer never wraps.
- R5: A pump-down with the bit at index 0 leaves the pointer unchanged. The pointer never wraps.
- R6: When both pump inputs are 1 on the same edge, the pointer holds. That edge counts as an error edge and not as a quiet edge.
- R7: `tap_ptr_o` has exactly one bit set on every cycle.
- R8: `tap_sel_o` equals the binary index of the set bit in `tap_ptr_o` on every cycle. Select 0 is the shortest delay and select 15 is the longest.
- R9: `locked_o` becomes 1 after the 4th consecutive rising edge with both pump inputs at 0. It stays 1 while the inputs stay quiet.
- R10: Any rising edge with either pump input at 1 leaves `locked_o` at 0 after that edge and restarts the quiet count.
- R11: When the block is connected to a tap-delay model that pumps toward a target tap, it settles on that tap and asserts lock within 40 cycles. This holds for targets at both ends of the line and in the middle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pump_up_i | input | 1 | Phase error: delayed copy early, lengthen delay |
| pump_dn_i | input | 1 | Phase error: delayed copy late, shorten delay |
| tap_sel_o | output | 4 | Binary tap select for the delay-line multiplexer |
| locked_o | output | 1 | Loop locked flag |
| tap_ptr_o | output | 16 | One-hot tap pointer, for observation |

## Verification
A corrupted shift register shows up at the ports on the next cycle. The pointer then has zero or two bits set, or the select disagrees with the pointer. The bench checks both conditions after every edge, so such a fault cannot stay hidden. A wrong shift direction or a missing end-stop shows up as a pointer one position away from the model's pointer, at the edge that applied the pulse. A fault in the quiet counter shows up as lock rising one edge too early or too late, or as lock failing to fall on the edge that samples an error.

// File: rtl/tap_lock_pkg.sv
package tap_lock_pkg;

  typedef enum logic [1:0] {
    MV_HOLD  = 2'd0,
    MV_LEFT  = 2'd1,
    MV_RIGHT = 2'd2
  } tap_move_e;

  // Opposing pulses cancel; a lone pulse picks the direction.
  function automatic tap_move_e decode_move(input logic up, input logic dn);
    if (up && !dn)      return MV_LEFT;
    else if (dn && !up) return MV_RIGHT;
    else                return MV_HOLD;
  endfunction

endpackage

// File: rtl/tap_ptr_shreg.sv
module tap_ptr_shreg #(
  parameter int NUM_TAPS  = 16,
  parameter int RESET_TAP = 0
) (
  input  logic                clk,
  input  logic                rst,
  input  tap_lock_pkg::tap_move_e move,
  output logic [NUM_TAPS-1:0] ptr_q,
  output logic [NUM_TAPS-1:0] ptr_d
);
  import tap_lock_pkg::*;

  localparam logic [NUM_TAPS-1:0] RESET_PTR = NUM_TAPS'(1) << RESET_TAP;

  always_comb begin
    ptr_d = ptr_q;
    unique case (move)
      MV_LEFT:  if (!ptr_q[NUM_TAPS-1]) ptr_d = ptr_q << 1;
      MV_RIGHT: if (!ptr_q[0])          ptr_d = ptr_q >> 1;
      default:  ptr_d = ptr_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) ptr_q <= RESET_PTR;
    else     ptr_q <= ptr_d;
  end

endmodule

// File: rtl/tap_onehot_enc.sv
module tap_onehot_enc #(
  parameter int NUM_TAPS  = 16,
  parameter int RESET_TAP = 0,
  localparam int SEL_W    = $clog2(NUM_TAPS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_TAPS-1:0] ptr_next,
  output logic [SEL_W-1:0]    sel_q
);

  logic [SEL_W-1:0] sel_d;

  // Priority encoder: the highest set bit wins.
  always_comb begin
    sel_d = '0;
    for (int i = 0; i < NUM_TAPS; i++) begin
      if (ptr_next[i]) sel_d = SEL_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) sel_q <= SEL_W'(RESET_TAP);
    else     sel_q <= sel_d;
  end

endmodule

// File: rtl/tap_lock_detect.sv
module tap_lock_detect #(
  parameter int LOCK_CYCLES = 4,
  localparam int CNT_W      = $clog2(LOCK_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic err,
  output logic locked_q
);

  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(LOCK_CYCLES);

  logic [CNT_W-1:0] quiet_q;
  logic [CNT_W-1:0] quiet_d;

  always_comb begin
    if (err)                    quiet_d = '0;
    else if (quiet_q == CNT_MAX) quiet_d = quiet_q;
    else                         quiet_d = quiet_q + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      quiet_q  <= '0;
      locked_q <= 1'b0;
    end else begin
      quiet_q  <= quiet_d;
      locked_q <= (quiet_d == CNT_MAX);
    end
  end

endmodule

// File: rtl/tap_lock_ctrl.sv
module tap_lock_ctrl #(
  parameter int NUM_TAPS    = 16,
  parameter int LOCK_CYCLES = 4,
  parameter int RESET_TAP   = 0
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        pump_up_i,
  input  logic                        pump_dn_i,
  output logic [$clog2(NUM_TAPS)-1:0] tap_sel_o,
  output logic                        locked_o,
  output logic [NUM_TAPS-1:0]         tap_ptr_o
);
  import tap_lock_pkg::*;

  tap_move_e           move;
  logic                err;
  logic [NUM_TAPS-1:0] ptr_next;

  assign move = decode_move(pump_up_i, pump_dn_i);
  assign err  = pump_up_i | pump_dn_i;

  tap_ptr_shreg #(.NUM_TAPS(NUM_TAPS), .RESET_TAP(RESET_TAP)) u_ptr (
    .clk   (clk),
    .rst   (rst),
    .move  (move),
    .ptr_q (tap_ptr_o),
    .ptr_d (ptr_next)
  );

  tap_onehot_enc #(.NUM_TAPS(NUM_TAPS), .RESET_TAP(RESET_TAP)) u_enc (
    .clk      (clk),
    .rst      (rst),
    .ptr_next (ptr_next),
    .sel_q    (tap_sel_o)
  );

  tap_lock_detect #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
    .clk      (clk),
    .rst      (rst),
    .err      (err),
    .locked_q (locked_o)
  );

endmodule

// File: rtl/tap_lock_checker.sv
module tap_lock_checker #(
  parameter int NUM_TAPS = 16
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        pump_up_i,
  input logic                        pump_dn_i,
  input logic [$clog2(NUM_TAPS)-1:0] tap_sel_o,
  input logic                        locked_o,
  input logic [NUM_TAPS-1:0]         tap_ptr_o
);

  p_onehot_r7: assert property (@(posedge clk) disable iff (rst)
    $countones(tap_ptr_o) == 1);

  p_sel_match_r8: assert property (@(posedge clk) disable iff (rst)
    tap_ptr_o[tap_sel_o] == 1'b1);

  p_shift_up_r2: assert property (@(posedge clk) disable iff (rst)
    (pump_up_i && !pump_dn_i && !tap_ptr_o[NUM_TAPS-1])
      |=> tap_ptr_o == ($past(tap_ptr_o) << 1));

  p_shift_dn_r3: assert property (@(posedge clk) disable iff (rst)
    (pump_dn_i && !pump_up_i && !tap_ptr_o[0])
      |=> tap_ptr_o == ($past(tap_ptr_o) >> 1));

  p_top_stop_r4: assert property (@(posedge clk) disable iff (rst)
    (pump_up_i && tap_ptr_o[NUM_TAPS-1]) |=> $stable(tap_ptr_o));

  p_bottom_stop_r5: assert property (@(posedge clk) disable iff (rst)
    (pump_dn_i && tap_ptr_o[0]) |=> $stable(tap_ptr_o));

  p_both_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (pump_up_i && pump_dn_i) |=> $stable(tap_ptr_o));

  p_lock_stays_r9: assert property (@(posedge clk) disable iff (rst)
    (locked_o && !pump_up_i && !pump_dn_i) |=> locked_o);

  p_lock_rise_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(locked_o) |-> $past(!pump_up_i && !pump_dn_i));

  p_lock_clear_r10: assert property (@(posedge clk) disable iff (rst)
    (pump_up_i || pump_dn_i) |=> !locked_o);

endmodule

bind tap_lock_ctrl tap_lock_checker #(.NUM_TAPS(NUM_TAPS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .pump_up_i (pump_up_i),
  .pump_dn_i (pump_dn_i),
  .tap_sel_o (tap_sel_o),
  .locked_o  (locked_o),
  .tap_ptr_o (tap_ptr_o)
);

// File: tb/tb_tap_lock_ctrl.sv
`timescale 1ns/1ps
module tb_tap_lock_ctrl;
  localparam int N     = 16;
  localparam int SW    = $clog2(N);
  localparam int LOCKN = 4;
  localparam int STEP_PS = 150;
  localparam int BASE_PS = 2000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          up = 1'b0;
  logic          dn = 1'b0;
  logic [SW-1:0] sel;
  logic          lk;
  logic [N-1:0]  ptr;

  int n_run  = 0;
  int n_fail = 0;

  int m_idx  = 0;
  int m_cnt  = 0;
  bit m_lock = 0;

  always #2.5 clk = ~clk;

  tap_lock_ctrl #(.NUM_TAPS(N), .LOCK_CYCLES(LOCKN), .RESET_TAP(0)) dut (
    .clk(clk), .rst(rst), .pump_up_i(up), .pump_dn_i(dn),
    .tap_sel_o(sel), .locked_o(lk), .tap_ptr_o(ptr)
  );

  function automatic int next_idx(int idx, bit u, bit d);
    if (u && !d && idx < N-1) return idx + 1;
    if (d && !u && idx > 0)   return idx - 1;
    return idx;
  endfunction

  // Behavioural tap-delay line plus phase detector: {up, dn}.
  function automatic logic [1:0] pd_model(int idx, int period_ps);
    int dly;
    dly = BASE_PS + idx * STEP_PS;
    if (dly < period_ps) return 2'b10;
    if (dly > period_ps) return 2'b01;
    return 2'b00;
  endfunction

  task automatic check(bit ok, string tag, longint act, longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_all(string ptag, string ltag);
    int cnt1;
    cnt1 = $countones(ptr);
    check(cnt1 == 1, "R7 one-hot", cnt1, 1);
    check(ptr[sel] === 1'b1, "R8 sel matches pointer", sel, m_idx);
    check(ptr == (N'(1) << m_idx), ptag, ptr, N'(1) << m_idx);
    check(sel == SW'(m_idx), ptag, sel, m_idx);
    check(lk == m_lock, ltag, lk, m_lock);
  endtask

  // Called at a negedge: drive, advance one edge, check at the next negedge.
  task automatic step(bit u, bit d);
    string ptag;
    string ltag;
    if (u && d)                 ptag = "R6 both pulses hold";
    else if (u && m_idx == N-1) ptag = "R4 top saturation";
    else if (u)                 ptag = "R2 shift up";
    else if (d && m_idx == 0)   ptag = "R5 bottom saturation";
    else if (d)                 ptag = "R3 shift down";
    else                        ptag = "R2 R3 quiet hold";
    ltag = (u || d) ? "R10 lock cleared" : "R9 lock after quiet run";
    up = u;
    dn = d;
    m_idx = next_idx(m_idx, u, d);
    if (u || d)          m_cnt = 0;
    else if (m_cnt < LOCKN) m_cnt++;
    m_lock = (m_cnt == LOCKN);
    @(posedge clk);
    @(negedge clk);
    check_all(ptag, ltag);
  endtask

  initial begin
    #(5.0 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [1:0] pdv;
    int r;
    int targets[3];
    void'($urandom(32'd20250611));
    repeat (3) @(negedge clk);
    check(ptr == N'(1) && sel == '0 && lk == 1'b0, "R1 reset state", {ptr, sel, lk}, 1 << (SW+1));
    rst = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check(ptr == N'(1) && sel == '0 && lk == 1'b0, "R1 after reset", {ptr, sel, lk}, 1 << (SW+1));

    // Walk to the top and past it.
    for (int i = 0; i < N + 3; i++) step(1, 0);
    check(sel == SW'(N-1), "R8 max select is 15", sel, N-1);
    // Walk to the bottom and past it.
    for (int i = 0; i < N + 3; i++) step(0, 1);
    check(sel == '0, "R8 min select is 0", sel, 0);
    step(1, 0);
    step(1, 1);
    step(1, 1);
    // Lock exactly after the 4th quiet edge.
    for (int i = 0; i < LOCKN - 1; i++) step(0, 0);
    check(lk == 1'b0, "R9 not locked after 3 quiet", lk, 0);
    step(0, 0);
    check(lk == 1'b1, "R9 locked after 4 quiet", lk, 1);
    step(0, 0);
    step(1, 0);
    check(lk == 1'b0, "R10 up clears lock", lk, 0);
    for (int i = 0; i < LOCKN; i++) step(0, 0);
    step(1, 1);
    check(lk == 1'b0, "R10 both clear lock", lk, 0);

    // Constrained random pulses.
    for (int i = 0; i < 1500; i++) begin
      r = int'($urandom % 10);
      if (r < 2)       step(1, 0);
      else if (r < 4)  step(0, 1);
      else if (r == 4) step(1, 1);
      else             step(0, 0);
    end

    // Closed loop against the tap-delay model.
    targets[0] = 0;
    targets[1] = N - 1;
    targets[2] = 7;
    foreach (targets[t]) begin
      for (int i = 0; i < 40; i++) begin
        pdv = pd_model(m_idx, BASE_PS + targets[t] * STEP_PS);
        step(pdv[1], pdv[0]);
      end
      check(sel == SW'(targets[t]), "R11 settles on target", sel, targets[t]);
      check(lk == 1'b1, "R11 locks on target", lk, 1);
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule